// File: doc/BRIEF.md
# Debug-Mode Core Clock Selector

This block chooses which clock drives a processor core. In normal running the core is clocked from the free-running memory clock. When a debug halt is requested, the core is moved onto a debug clock that is built from the test clock. A halt request is the debug-state flag, a breakpoint hit, a watchpoint hit or an external debug request. The debug clock produces a pulse only in test-clock cycles that the TAP state machine enables through a per-cycle run strobe. At all other times it stays low. The memory clock keeps running throughout.

Changing from one source to the other is break-before-make. The enable of the clock currently in use is dropped on that clock's falling edge through a synchronizer chain in its own domain. Only after that does the other chain raise its enable, so the core never sees a truncated high phase. Whichever clock is driving the core is also copied to an exported clock for the rest of the system. A status output reports the active source once a switch has finished. The external wait input passes through to the core in normal running and is forced inactive while the core runs on the debug clock.

Top module: `dbgclk_sel`

## Requirements
- R1: While `rst_n` is low, `clk_src` reads 2'b01 (memory clock selected), `dbg_clk` is low, and `core_clk` follows `mem_clk`.
- R2: While `clk_src` is 2'b01, `core_clk` is high in every high phase of `mem_clk` and low in every low phase. `dbg_clk` stays low whatever `tap_run` does.
- R3: Each of `dbg_state`, `brk_hit`, `wpt_hit` and `ext_dbg_req` held high on its own moves `clk_src` to 2'b10 (debug clock selected) within 80 memory-clock cycles.
- R4: While `clk_src` is 2'b10, `dbg_clk` gives exactly one pulse, one full `test_clk` high phase long, for each falling edge of `test_clk` at which `tap_run` is sampled high. `core_clk` carries the same pulses.
- R5: `eclk` always equals `core_clk`.
- R6: `eff_wait` equals `ext_wait` unless `clk_src` is 2'b10. When `clk_src` is 2'b10, `eff_wait` is low.
- R7: A switch passes through `clk_src` = 2'b00 (neither clock enabled). `clk_src` never reads 2'b11. No high pulse on `core_clk` is shorter than a half period of its source clock.
- R8: When all four halt inputs go low, `clk_src` returns to 2'b01 within 80 memory-clock cycles, and `dbg_clk` stays low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Free-running memory clock |
| test_clk | input | 1 | Test clock that the debug clock is built from |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_state | input | 1 | Core is held in debug state |
| brk_hit | input | 1 | Breakpoint match on an instruction fetch |
| wpt_hit | input | 1 | Watchpoint match on a data access |
| ext_dbg_req | input | 1 | External debug request |
| tap_run | input | 1 | Per-cycle enable from the TAP state machine, sampled on the falling edge of test_clk |
| ext_wait | input | 1 | External wait request |
| dbg_clk | output | 1 | Gated debug clock |
| core_clk | output | 1 | Clock that drives the core |
| eclk | output | 1 | Copy of the selected clock for the system |
| eff_wait | output | 1 | Wait as the core sees it |
| clk_src | output | 2 | Active source: 01 memory, 10 debug, 00 switch in progress |

## Verification
Each of the four halt inputs is raised on its own, so a missing term in the request OR shows up as a switch that never completes. Every debug visit runs a different `tap_run` pattern (a solid burst, alternating cycles, a lone pulse, an irregular word). Pulse counts on `dbg_clk`, `core_clk` and `eclk` are compared with the number of enabled falling edges, which separates a lost or extra pulse from correct gating. Toggling `tap_run` and `ext_wait` in memory mode shows that the run strobe cannot leak a pulse and that the wait mask depends on the selected source. A monitor that measures every core-clock high phase catches a truncated pulse at a switch.

// File: rtl/dbgclk_pkg.sv
`timescale 1ns/1ps
package dbgclk_pkg;
   typedef enum logic [1:0] {
      SRC_SWITCH = 2'b00,
      SRC_MEM    = 2'b01,
      SRC_DBG    = 2'b10
   } clk_src_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/dbgclk_sync.sv
`timescale 1ns/1ps
// Falling-edge enable synchronizer chain for one clock domain.
// q is the last stage; busy is high while any stage holds a one.
module dbgclk_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic busy
);
   import dbgclk_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("dbgclk_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q    = chain[STAGES-1];
   assign busy = |chain;
endmodule

// File: rtl/dbgclk_gate.sv
`timescale 1ns/1ps
// AND-style clock gate. en must change only on the falling edge of clk.
// With REG_QUAL set, an extra qualifier is captured on the falling edge
// and also gates the clock; otherwise the qualifier is unused.
module dbgclk_gate #(
   parameter bit REG_QUAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic qual,
   output logic gclk
);
   logic qual_q;

   if (REG_QUAL) begin : g_reg_qual
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) qual_q <= 1'b0;
         else        qual_q <= qual;
      end
   end else begin : g_no_qual
      logic unused_qual;
      assign unused_qual = qual;
      assign qual_q      = 1'b1;
   end

   assign gclk = clk & en & qual_q;

   AST_GATE_PASSES: assert property (@(negedge clk) disable iff (!rst_n)
      (en && qual_q) |-> gclk) else $error("gate blocked an enabled phase"); // R4
endmodule

// File: rtl/dbgclk_sel.sv
`timescale 1ns/1ps
module dbgclk_sel #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       mem_clk,
   input  logic       test_clk,
   input  logic       rst_n,
   input  logic       dbg_state,
   input  logic       brk_hit,
   input  logic       wpt_hit,
   input  logic       ext_dbg_req,
   input  logic       tap_run,
   input  logic       ext_wait,
   output logic       dbg_clk,
   output logic       core_clk,
   output logic       eclk,
   output logic       eff_wait,
   output logic [1:0] clk_src
);
   import dbgclk_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_cfg
      $error("dbgclk_sel: SYNC_STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic want_dbg;
   logic mem_en, mem_busy, mem_d;
   logic dbg_en, dbg_busy, dbg_d;
   logic mem_gclk;

   // Any halt source asks for the debug clock.
   assign want_dbg = dbg_state | brk_hit | wpt_hit | ext_dbg_req;

   // Break-before-make: each side may start only while the other chain is empty.
   assign mem_d = ~want_dbg & ~dbg_busy;
   assign dbg_d =  want_dbg & ~mem_busy;

   dbgclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mem_sync (
      .clk(mem_clk), .rst_n(rst_n), .d(mem_d), .q(mem_en), .busy(mem_busy));

   dbgclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dbg_sync (
      .clk(test_clk), .rst_n(rst_n), .d(dbg_d), .q(dbg_en), .busy(dbg_busy));

   dbgclk_gate #(.REG_QUAL(1'b0)) u_mem_gate (
      .clk(mem_clk), .rst_n(rst_n), .en(mem_en), .qual(1'b1), .gclk(mem_gclk));

   dbgclk_gate #(.REG_QUAL(1'b1)) u_dbg_gate (
      .clk(test_clk), .rst_n(rst_n), .en(dbg_en), .qual(tap_run), .gclk(dbg_clk));

   assign core_clk = mem_gclk | dbg_clk;
   assign eclk     = core_clk;
   assign eff_wait = ext_wait & ~dbg_en;
   assign clk_src  = {dbg_en, mem_en};

   AST_SRC_EXCLUSIVE: assert property (@(posedge mem_clk) disable iff (!rst_n)
      $onehot0(clk_src)) else $error("both clock enables high"); // R7
   AST_DCLK_IDLE: assert property (@(negedge test_clk) disable iff (!rst_n)
      !dbg_en |-> !dbg_clk) else $error("debug clock pulsed while deselected"); // R8
   AST_CORE_ON_MEM: assert property (@(negedge mem_clk) disable iff (!rst_n)
      mem_en |-> core_clk) else $error("core clock missed a memory phase"); // R2
   AST_WAIT_IGNORED: assert property (@(posedge mem_clk) disable iff (!rst_n)
      dbg_en |-> !eff_wait) else $error("wait reached core in debug"); // R6
endmodule

// File: tb/dbgclk_sel_tb.sv
`timescale 1ns/1ps
module dbgclk_sel_tb;
   logic mem_clk = 1'b0, test_clk = 1'b0, rst_n = 1'b0;
   logic dbg_state = 0, brk_hit = 0, wpt_hit = 0, ext_dbg_req = 0;
   logic tap_run = 0, ext_wait = 0;
   logic dbg_clk, core_clk, eclk, eff_wait;
   logic [1:0] clk_src;

   int tests = 0, fails = 0;
   int dclk_cnt = 0, core_cnt = 0, eclk_cnt = 0, exp_pulses = 0;
   int glitches = 0, excl_bad = 0, follow_bad = 0, eclk_bad = 0, wait_bad = 0, dclk_bad = 0;
   bit win = 0, saw_switch = 0, done = 0;
   realtime t_rise = 0.0;

   always #2.5 mem_clk  = ~mem_clk;   // 200 MHz
   always #6.5 test_clk = ~test_clk;

   dbgclk_sel u_dut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Reference monitors
   always @(posedge core_clk) begin t_rise = $realtime; core_cnt++; end
   always @(negedge core_clk) if (rst_n && ($realtime - t_rise) < 2.4) glitches++;
   always @(posedge dbg_clk) dclk_cnt++;
   always @(posedge eclk) eclk_cnt++;
   always @(negedge test_clk) if (win && tap_run) exp_pulses++;
   always @(negedge mem_clk) if (rst_n) begin
      if (clk_src == 2'b11) excl_bad++;
      if (clk_src == 2'b00) saw_switch = 1;
   end
   always @(posedge mem_clk) begin
      #1;
      if (eclk !== core_clk) eclk_bad++;
      if (eff_wait !== ((clk_src == 2'b10) ? 1'b0 : ext_wait)) wait_bad++;
      if (clk_src == 2'b01 && core_clk !== 1'b1) follow_bad++;
   end
   always @(negedge mem_clk) begin
      #1;
      if (clk_src == 2'b01 && core_clk !== 1'b0) follow_bad++;
   end
   always @(posedge test_clk) begin
      #1;
      if (clk_src == 2'b01 && dbg_clk !== 1'b0) dclk_bad++;
   end

   task automatic set_trig(input int i, input bit v);
      case (i)
         0: dbg_state   = v;
         1: brk_hit     = v;
         2: wpt_hit     = v;
         default: ext_dbg_req = v;
      endcase
   endtask

   task automatic wait_src(input logic [1:0] target, input string req);
      for (int i = 0; i < 80; i++) begin
         @(negedge mem_clk);
         if (clk_src == target) break;
      end
      #1;
      chk(clk_src == target, req, "clk_src after switch", clk_src, target);
   endtask

   task automatic run_pulses(input logic [15:0] pat, input int n);
      @(posedge test_clk); #1 tap_run = 0;
      repeat (2) @(posedge test_clk);
      #1;
      dclk_cnt = 0; core_cnt = 0; eclk_cnt = 0; exp_pulses = 0; win = 1;
      for (int k = 0; k < n; k++) begin
         @(posedge test_clk); #1 tap_run = pat[k];
      end
      @(posedge test_clk); #1 tap_run = 0;
      repeat (2) @(posedge test_clk);
      #1 win = 0;
      chk(dclk_cnt == exp_pulses, "R4", "dbg_clk pulses", dclk_cnt, exp_pulses);
      chk(core_cnt == exp_pulses, "R4", "core_clk pulses", core_cnt, exp_pulses);
      chk(eclk_cnt == core_cnt, "R5", "eclk pulses", eclk_cnt, core_cnt);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #500000;
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] pats [4];
      int lens [4];
      pats[0] = 16'h003F; lens[0] = 6;
      pats[1] = 16'h0055; lens[1] = 8;
      pats[2] = 16'h0001; lens[2] = 1;
      pats[3] = 16'h0B6D; lens[3] = 12;

      // R1: reset state
      repeat (4) @(posedge mem_clk);
      #1;
      chk(clk_src == 2'b01, "R1", "clk_src in reset", clk_src, 1);
      chk(dbg_clk == 1'b0, "R1", "dbg_clk in reset", dbg_clk, 0);
      chk(core_clk == 1'b1, "R1", "core_clk high phase in reset", core_clk, 1);
      @(posedge mem_clk); #0.5 rst_n = 1;

      // R2: memory mode, tap_run toggling must not leak
      dclk_cnt = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge test_clk); #1 tap_run = ~tap_run;
      end
      #1 tap_run = 0;
      repeat (2) @(posedge test_clk);
      chk(dclk_cnt == 0, "R2", "dbg_clk pulses in memory mode", dclk_cnt, 0);
      @(posedge mem_clk); #1;
      chk(core_clk == 1'b1, "R2", "core_clk high phase", core_clk, 1);
      @(negedge mem_clk); #1;
      chk(core_clk == 1'b0, "R2", "core_clk low phase", core_clk, 0);

      // R6: wait passes in memory mode
      ext_wait = 1; #1;
      chk(eff_wait == 1'b1, "R6", "eff_wait in memory mode", eff_wait, 1);
      ext_wait = 0;

      for (int t = 0; t < 4; t++) begin
         saw_switch = 0;
         set_trig(t, 1);
         wait_src(2'b10, "R3");
         chk(saw_switch, "R7", "passed through 00", saw_switch, 1);
         ext_wait = 1; #1;
         chk(eff_wait == 1'b0, "R6", "eff_wait in debug", eff_wait, 0);
         run_pulses(pats[t], lens[t]);
         ext_wait = 0;
         set_trig(t, 0);
         wait_src(2'b01, "R8");
         dclk_cnt = 0;
         repeat (4) @(posedge test_clk);
         chk(dclk_cnt == 0, "R8", "dbg_clk after return", dclk_cnt, 0);
      end

      chk(glitches == 0, "R7", "short core_clk pulses", glitches, 0);
      chk(excl_bad == 0, "R7", "both sources enabled", excl_bad, 0);
      chk(follow_bad == 0, "R2", "core_clk vs mem_clk mismatches", follow_bad, 0);
      chk(dclk_bad == 0, "R2", "dbg_clk high in memory mode", dclk_bad, 0);
      chk(eclk_bad == 0, "R5", "eclk vs core_clk mismatches", eclk_bad, 0);
      chk(wait_bad == 0, "R6", "eff_wait model mismatches", wait_bad, 0);
      finish_run();
   end
endmodule